// File: doc/BRIEF.md
# Vertical Scan and Gate-Enable Sequencer

This block drives the row side of a small active-matrix display. A frame strobe opens a field and picks the scan direction. Each later line strobe selects one more gate line. For every selected line, the block makes one edge on a pair of complementary vertical shift clocks. Each edge has a precharge pulse that ends a fixed time before it and a gate-enable pulse that starts a fixed time after it. A start pulse frames the first edge of the field. It begins a set-up time before that edge and ends a hold time after it.

All delays are given in nanoseconds and turned into cycles of the base clock. The vertical clock edge lags each accepted line strobe by a fixed time. This lets the precharge pulse be placed ahead of the edge without predicting the next line strobe. After the last gate line of a field the clocks stop. Gate-enable and precharge then stay low until the next frame strobe. A frame strobe that arrives during a scan cancels all pending pulses and starts a new field.

All pins are plain control pins. There is no stream interface, so no back-pressure applies.

Top module: `vert_scan_seq`

## Requirements
- R1: Each accepted line strobe makes one vertical clock edge. The edge appears round(EDGE_LAG_NS/CLK_NS)+1 cycles after the cycle in which the strobe is sampled.
- R2: `vck_b_o` is always the complement of `vck_a_o`. The rest level is `vck_a_o` low, and it applies after reset and after every frame strobe.
- R3: `gate_en_o` rises round(EN_DLY_NS/CLK_NS) cycles after each vertical clock edge. It stays high for round(EN_W_NS/CLK_NS) cycles.
- R4: `prechg_o` is high for round(PCG_W_NS/CLK_NS) cycles before each vertical clock edge. It falls round(PCG_LEAD_NS/CLK_NS) cycles before that edge.
- R5: `vst_o` rises round(VST_SETUP_NS/CLK_NS) cycles before the first edge of a field. It falls round(VST_HOLD_NS/CLK_NS) cycles after that edge.
- R6: A field holds exactly LINES edges. Line strobes after the last one are ignored and change no output.
- R7: `line_idx_o` shows the most recently selected gate line, and 0 when no line has been selected in the field.
  - With `scan_down_i`=1 at the frame strobe, it steps 1, 2, … LINES.
  - With `scan_down_i`=0 at the frame strobe, it steps LINES, LINES-1, … 1.
  - It changes in the same cycle as the vertical clock edge.
- R8: A frame strobe during a scan takes effect in the cycle after it is sampled. In that cycle `vst_o`, `gate_en_o` and `prechg_o` drop, the clocks return to rest and `line_idx_o` returns to 0. The next line strobe then starts a new field.
- R9: Line strobes before the first frame strobe after reset are ignored.
- R10: In reset, `vst_o`, `gate_en_o`, `prechg_o` and `vck_a_o` are 0, `vck_b_o` is 1 and `line_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb_i | input | 1 | One-cycle field start strobe |
| line_stb_i | input | 1 | One-cycle line period strobe |
| scan_down_i | input | 1 | Scan direction, sampled with the frame strobe (1 = downward) |
| vst_o | output | 1 | Vertical start pulse |
| vck_a_o | output | 1 | Vertical shift clock, first phase |
| vck_b_o | output | 1 | Vertical shift clock, complementary phase |
| gate_en_o | output | 1 | Gate-enable pulse |
| prechg_o | output | 1 | Uniformity precharge pulse |
| line_idx_o | output | $clog2(LINES+1) | Selected gate line, 0 when none |

## Verification
The bench predicts the exact cycle of every transition on every output. Two corner cases get the most attention:
- The end of a field: extra line strobes must not produce a further clock edge, index step or pulse. A design that counts edges wrongly would add a spurious toggle or miss the last gate-enable.
- A restart in mid-field, timed while the start pulse is still high and the clocks are at their high level. A design that fails to abort would leave the start pulse high until its old fall time, or keep a stale index.

Upward scans and strobes sent before any field are also covered. A wrong direction latch would show reversed index order, and a missing idle gate would clock the panel with no field open.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_RUN  = 1'b1
  } scan_state_e;

  // Nearest whole number of base-clock cycles for a time in ns.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns / 2) / clk_ns;
  endfunction

  // Timer slots in the pulse bank.
  localparam int TMR_EDGE = 0;
  localparam int TMR_PCG  = 1;
  localparam int TMR_VST  = 2;
  localparam int TMR_EN   = 3;
  localparam int TMR_N    = 4;

endpackage

// File: rtl/vsq_pulse_timer.sv
// Delayed one-shot: a trigger sampled at edge k gives a pulse that is high
// from edge k+DLY for WID cycles. A new trigger restarts it; abort clears it.
module vsq_pulse_timer #(
  parameter int DLY = 1,
  parameter int WID = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic abort_i,
  output logic pulse_o
);

  localparam int TOTAL = DLY + WID;
  localparam int CW    = $clog2(TOTAL + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (trig_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == CW'(TOTAL - 1)) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pulse_o = run_q && (cnt_q >= CW'(DLY));

  AST_TMR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < CW'(TOTAL))); // R3

  AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !trig_i) |=> !pulse_o); // R6

endmodule

// File: rtl/vsq_scan_ctrl.sv
// Field state, line acceptance, clock phase and gate-line index.
module vsq_scan_ctrl
  import vsq_pkg::*;
#(
  parameter int LINES = 225
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_stb_i,
  input  logic                          line_stb_i,
  input  logic                          scan_down_i,
  input  logic                          edge_tick_i,
  output logic                          accept_o,
  output logic                          first_o,
  output logic                          vck_a_o,
  output logic                          vck_b_o,
  output logic [$clog2(LINES+1)-1:0]    line_idx_o
);

  localparam int CNTW = $clog2(LINES + 1);

  scan_state_e     st_q;
  logic [CNTW-1:0] issued_q;
  logic [CNTW-1:0] edges_q;
  logic            dir_down_q;
  logic            vck_a_q;
  logic            vck_b_q;
  logic [CNTW-1:0] idx_q;
  logic [CNTW-1:0] idx_next;
  logic            do_edge;

  assign accept_o = (st_q == SC_RUN) && line_stb_i && !frame_stb_i &&
                    (issued_q < CNTW'(LINES));
  assign first_o  = accept_o && (issued_q == '0);
  assign do_edge  = (st_q == SC_RUN) && edge_tick_i && !frame_stb_i;
  assign idx_next = dir_down_q ? (edges_q + 1'b1) : (CNTW'(LINES) - edges_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SC_IDLE;
      issued_q   <= '0;
      edges_q    <= '0;
      dir_down_q <= 1'b1;
      vck_a_q    <= 1'b0;
      vck_b_q    <= 1'b1;
      idx_q      <= '0;
    end else if (frame_stb_i) begin
      st_q       <= SC_RUN;
      issued_q   <= '0;
      edges_q    <= '0;
      dir_down_q <= scan_down_i;
      vck_a_q    <= 1'b0;
      vck_b_q    <= 1'b1;
      idx_q      <= '0;
    end else begin
      if (accept_o) begin
        issued_q <= issued_q + 1'b1;
      end
      if (do_edge) begin
        vck_a_q <= ~vck_a_q;
        vck_b_q <= vck_a_q;
        edges_q <= edges_q + 1'b1;
        idx_q   <= idx_next;
        if (edges_q == CNTW'(LINES - 1)) begin
          st_q <= SC_IDLE;
        end
      end
    end
  end

  assign vck_a_o    = vck_a_q;
  assign vck_b_o    = vck_b_q;
  assign line_idx_o = idx_q;

  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    edges_q <= CNTW'(LINES)); // R6

  AST_EDGES_TRAIL_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    edges_q <= issued_q); // R1

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= CNTW'(LINES)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_IDLE && !frame_stb_i) |=> $stable(vck_a_q)); // R6

  AST_FRAME_REST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_i |=> (!vck_a_q && idx_q == '0)); // R8

endmodule

// File: rtl/vert_scan_seq.sv
// Top: controller plus a bank of four delayed one-shots.
module vert_scan_seq
  import vsq_pkg::*;
#(
  parameter int CLK_NS       = 20,
  parameter int LINES        = 225,
  parameter int EDGE_LAG_NS  = 5000,
  parameter int VST_SETUP_NS = 4500,
  parameter int VST_HOLD_NS  = 59000,
  parameter int EN_DLY_NS    = 2200,
  parameter int EN_W_NS      = 6000,
  parameter int PCG_W_NS     = 2500,
  parameter int PCG_LEAD_NS  = 1000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_stb_i,
  input  logic                       line_stb_i,
  input  logic                       scan_down_i,
  output logic                       vst_o,
  output logic                       vck_a_o,
  output logic                       vck_b_o,
  output logic                       gate_en_o,
  output logic                       prechg_o,
  output logic [$clog2(LINES+1)-1:0] line_idx_o
);

  localparam int EDGE_C  = ns_to_cyc(EDGE_LAG_NS, CLK_NS);
  localparam int TO_VCK  = EDGE_C + 1;
  localparam int SETUP_C = ns_to_cyc(VST_SETUP_NS, CLK_NS);
  localparam int HOLD_C  = ns_to_cyc(VST_HOLD_NS, CLK_NS);
  localparam int EN_D_C  = ns_to_cyc(EN_DLY_NS, CLK_NS);
  localparam int EN_W_C  = ns_to_cyc(EN_W_NS, CLK_NS);
  localparam int PCG_W_C = ns_to_cyc(PCG_W_NS, CLK_NS);
  localparam int PCG_L_C = ns_to_cyc(PCG_LEAD_NS, CLK_NS);
  localparam int PCG_D_C = TO_VCK - PCG_L_C - PCG_W_C;
  localparam int VST_D_C = TO_VCK - SETUP_C;
  localparam int VST_W_C = SETUP_C + HOLD_C;

  localparam int TMR_DLY [TMR_N] = '{EDGE_C, PCG_D_C, VST_D_C, EN_D_C};
  localparam int TMR_WID [TMR_N] = '{1, PCG_W_C, VST_W_C, EN_W_C};

  logic             accept;
  logic             first;
  logic [TMR_N-1:0] tmr_trig;
  logic [TMR_N-1:0] tmr_out;

  vsq_scan_ctrl #(
    .LINES (LINES)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_stb_i (frame_stb_i),
    .line_stb_i  (line_stb_i),
    .scan_down_i (scan_down_i),
    .edge_tick_i (tmr_out[TMR_EDGE]),
    .accept_o    (accept),
    .first_o     (first),
    .vck_a_o     (vck_a_o),
    .vck_b_o     (vck_b_o),
    .line_idx_o  (line_idx_o)
  );

  assign tmr_trig[TMR_EDGE] = accept;
  assign tmr_trig[TMR_PCG]  = accept;
  assign tmr_trig[TMR_VST]  = first;
  assign tmr_trig[TMR_EN]   = tmr_out[TMR_EDGE];

  for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
    vsq_pulse_timer #(
      .DLY (TMR_DLY[g]),
      .WID (TMR_WID[g])
    ) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (tmr_trig[g]),
      .abort_i (frame_stb_i),
      .pulse_o (tmr_out[g])
    );
  end

  assign vst_o     = tmr_out[TMR_VST];
  assign gate_en_o = tmr_out[TMR_EN];
  assign prechg_o  = tmr_out[TMR_PCG];

  AST_VCK_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    vck_a_o != vck_b_o); // R2

  AST_EDGE_CLEAR_PCG: assert property (@(posedge clk) disable iff (!rst_n)
    (vck_a_o != $past(vck_a_o)) |-> !prechg_o); // R4

  AST_EDGE_CLEAR_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (vck_a_o != $past(vck_a_o)) |-> !gate_en_o); // R3

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_i |=> (!vst_o && !gate_en_o && !prechg_o)); // R8

endmodule

// File: tb/vert_scan_seq_tb_top.sv
module vert_scan_seq_tb_top;

  localparam int CLK_NS = 20;
  localparam int L      = 6;
  localparam int IW     = $clog2(L + 1);
  // Expected cycle offsets, derived from the default ns values.
  localparam int E   = 5000 / CLK_NS + 1;
  localparam int PW  = 2500 / CLK_NS;
  localparam int PD  = E - 1000 / CLK_NS - PW;
  localparam int VSU = 4500 / CLK_NS;
  localparam int VHD = 59000 / CLK_NS;
  localparam int GD  = 2200 / CLK_NS;
  localparam int GW  = 6000 / CLK_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic line_stb = 1'b0;
  logic scan_down = 1'b1;
  logic vst, vck_a, vck_b, gate_en, prechg;
  logic [IW-1:0] line_idx;

  always #10 clk = ~clk;

  vert_scan_seq #(.CLK_NS(CLK_NS), .LINES(L)) dut_i (
    .clk (clk), .rst_n (rst_n), .frame_stb_i (frame_stb),
    .line_stb_i (line_stb), .scan_down_i (scan_down),
    .vst_o (vst), .vck_a_o (vck_a), .vck_b_o (vck_b),
    .gate_en_o (gate_en), .prechg_o (prechg), .line_idx_o (line_idx)
  );

  typedef struct {int cyc; int val; int req;} ev_t;
  ev_t q_vst[$];
  ev_t q_vck[$];
  ev_t q_en[$];
  ev_t q_pcg[$];
  ev_t q_idx[$];

  int checks = 0;
  int errors = 0;
  int pcnt = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  // Reference model state
  int m_vck = 0, m_idx = 0, m_n = 0, m_dir = 1, m_active = 0;
  int m_trunc = 0, m_vst_pend = -1;

  always @(posedge clk) pcnt <= pcnt + 1;

  task automatic check(input bit ok, input int req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic push(input int sig, input int cyc, input int val, input int req);
    ev_t e;
    e.cyc = cyc; e.val = val; e.req = req;
    case (sig)
      0: q_vst.push_back(e);
      1: q_vck.push_back(e);
      2: q_en.push_back(e);
      3: q_pcg.push_back(e);
      default: q_idx.push_back(e);
    endcase
  endtask

  // Monitor side: pop the expected change for a signal and compare.
  task automatic take(input int sig, input string name, input int val, input int t);
    ev_t e;
    bit have = 1'b0;
    int dreq;
    case (sig)
      0: begin dreq = 5; if (q_vst.size() > 0) begin e = q_vst.pop_front(); have = 1'b1; end end
      1: begin dreq = 1; if (q_vck.size() > 0) begin e = q_vck.pop_front(); have = 1'b1; end end
      2: begin dreq = 3; if (q_en.size()  > 0) begin e = q_en.pop_front();  have = 1'b1; end end
      3: begin dreq = 4; if (q_pcg.size() > 0) begin e = q_pcg.pop_front(); have = 1'b1; end end
      default: begin dreq = 7; if (q_idx.size() > 0) begin e = q_idx.pop_front(); have = 1'b1; end end
    endcase
    if (!have) begin
      check(1'b0, dreq, {name, " unexpected change at cycle"}, t, -1);
    end else begin
      check(e.cyc == t, e.req, {name, " change cycle"}, t, e.cyc);
      check(e.val == val, e.req, {name, " value"}, val, e.val);
    end
    if (sig == 1) check(vck_b == ~vck_a, 2, "vck_b complement", int'(vck_b), int'(~vck_a));
  endtask

  logic p_vst, p_vck, p_en, p_pcg;
  logic [IW-1:0] p_idx;

  always @(negedge clk) begin
    if (mon_on) begin
      if (vst !== p_vst)      begin take(0, "vst", int'(vst), pcnt);      p_vst = vst; end
      if (vck_a !== p_vck)    begin take(1, "vck_a", int'(vck_a), pcnt);  p_vck = vck_a; end
      if (gate_en !== p_en)   begin take(2, "gate_en", int'(gate_en), pcnt); p_en = gate_en; end
      if (prechg !== p_pcg)   begin take(3, "prechg", int'(prechg), pcnt); p_pcg = prechg; end
      if (line_idx !== p_idx) begin take(4, "line_idx", int'(line_idx), pcnt); p_idx = line_idx; end
    end
  end

  // Driver side: strobes plus expected events.
  task automatic send_line();
    int k, t;
    @(negedge clk);
    line_stb = 1'b1;
    k = pcnt + 1;
    @(negedge clk);
    line_stb = 1'b0;
    if (m_active != 0 && m_n < L) begin
      t = k + E;
      push(3, k + PD, 1, 4);            // R4
      push(3, k + PD + PW, 0, 4);
      m_vck = 1 - m_vck;
      push(1, t, m_vck, 1);             // R1
      m_n++;
      m_idx = (m_dir != 0) ? m_n : (L + 1 - m_n);
      push(4, t, m_idx, 7);             // R7
      push(2, t + GD, 1, 3);            // R3
      push(2, t + GD + GW, 0, 3);
      if (m_n == 1) begin
        push(0, t - VSU, 1, 5);         // R5
        if (m_trunc != 0) m_vst_pend = t + VHD;
        else push(0, t + VHD, 0, 5);
      end
    end
  endtask

  task automatic send_frame(input bit dir);
    int kf;
    @(negedge clk);
    frame_stb = 1'b1;
    scan_down = dir;
    kf = pcnt + 1;
    @(negedge clk);
    frame_stb = 1'b0;
    if (m_vck != 0) push(1, kf, 0, 8);      // R8
    if (m_idx != 0) push(4, kf, 0, 8);
    if (m_vst_pend >= 0) push(0, kf, 0, 8);
    m_vst_pend = -1;
    m_vck = 0; m_idx = 0; m_n = 0; m_dir = int'(dir); m_active = 1;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      send_line();
      repeat (798) @(negedge clk);
    end
  endtask

  task automatic quiet(input int req, input string what);
    int left;
    left = q_vst.size() + q_vck.size() + q_en.size() + q_pcg.size() + q_idx.size();
    check(left == 0, req, {what, ": pending expected changes"}, left, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    check(vst == 1'b0, 10, "reset vst", int'(vst), 0);
    check(gate_en == 1'b0, 10, "reset gate_en", int'(gate_en), 0);
    check(prechg == 1'b0, 10, "reset prechg", int'(prechg), 0);
    check(line_idx == '0, 10, "reset line_idx", int'(line_idx), 0);
    check(vck_a == 1'b0 && vck_b == 1'b1, 2, "reset clock rest level",
          int'({vck_a, vck_b}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    p_vst = vst; p_vck = vck_a; p_en = gate_en; p_pcg = prechg; p_idx = line_idx;
    mon_on = 1'b1;

    // R9: strobe before any field
    send_line();
    repeat (800) @(negedge clk);
    quiet(9, "stray strobe before field");
    check(vck_a == 1'b0 && line_idx == '0, 9, "outputs after stray strobe",
          int'(line_idx), 0);

    // Downward field with two surplus strobes (R6, R7)
    send_frame(1'b1);
    repeat (100) @(negedge clk);
    lines(L + 2);
    repeat (800) @(negedge clk);
    quiet(6, "downward field end");
    check(int'(line_idx) == L, 7, "last index downward", int'(line_idx), L);
    check(vck_a == 1'b0, 6, "clock level after full field", int'(vck_a), 0);

    // Upward field (R7)
    send_frame(1'b0);
    repeat (100) @(negedge clk);
    lines(L);
    repeat (800) @(negedge clk);
    quiet(7, "upward field end");
    check(int'(line_idx) == 1, 7, "last index upward", int'(line_idx), 1);

    // Mid-field restart (R8)
    send_frame(1'b1);
    m_trunc = 1;
    repeat (100) @(negedge clk);
    send_line();
    repeat (798) @(negedge clk);
    send_line();
    repeat (798) @(negedge clk);
    send_line();
    repeat (698) @(negedge clk);
    m_trunc = 0;
    check(vst == 1'b1 && vck_a == 1'b1, 8, "state before restart",
          int'({vst, vck_a}), 3);
    send_frame(1'b0);
    @(negedge clk);
    check(vst == 1'b0 && vck_a == 1'b0 && line_idx == '0, 8, "state after restart",
          int'({vst, vck_a}), 0);
    repeat (100) @(negedge clk);
    lines(L);
    repeat (800) @(negedge clk);
    quiet(8, "field after restart");
    check(int'(line_idx) == 1, 8, "index after restarted field", int'(line_idx), 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule